// File: doc/BRIEF.md
# Prescaled Event Timer

An 8-bit up-counter that the processor can load and read, advanced either once per instruction cycle or by edges arriving on an external input pin. An optional 8-bit prescaler can sit in front of the counter and divide the chosen event stream by a power of two. A set of static configuration inputs chooses the source, the active pin edge, whether the prescaler is used, and the division ratio.

The block runs on the oscillator clock. A 2-bit phase input marks the four oscillator clocks of each instruction cycle, and the clock edge at phase 3 is the instruction boundary. The pin is brought into the clock domain by a synchroniser. The prescaler output, or the pin level when the prescaler is not used, is sampled at phases 0 and 2 to find rising edges. Each increment request passes through a two-boundary delay line before it reaches the counter. A load from the processor empties that delay line and resets the prescaler, so the counter holds the loaded value for two instruction cycles before it moves again.

Top module: `event_timer`

## Requirements
- R1: While rstN is low, and right after it is released, rdData reads 00h.
- R2: With srcExt=0 and psBypass=1, the counter rises by exactly one at every instruction boundary, which is the clock edge that samples phase==3. It changes at no other edge.
- R3: The counter wraps from FFh to 00h on an increment and keeps counting.
- R4: wrEn high at an instruction boundary loads wrData at that edge. rdData shows the new value from then on.
- R5: After a load, the next two instruction boundaries bring no increment. With srcExt=0 and psBypass=1, the counter reads V, V, V, V+1 after boundaries w, w+1, w+2, w+3 following a load of V at boundary w.
- R6: With psBypass=0, the 3-bit psSel code k divides the event stream by 2^(k+1). With srcExt=0, after a load at boundary w, increments land at boundaries w+2^k+3+i*2^(k+1), for i = 0, 1, 2, ...
- R7: A load clears the prescaler when it is in use. The R6 schedule therefore restarts from the load, whatever count the prescaler had reached.
- R8: With srcExt=0, activity on extPin has no effect on the count.
- R9: With srcExt=1 and psBypass=1, each active pin edge adds one within six instruction cycles. edgeFall=0 selects the rising edge and edgeFall=1 selects the falling edge. The other edge does not count.
- R10: With srcExt=1 and psBypass=0, the prescaler steps on each active pin edge. After a load, P edges give floor((P+2^k)/2^(k+1)) increments.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Active-low synchronous reset |
| phase | input | 2 | Position within the instruction cycle; 3 marks the boundary edge |
| extPin | input | 1 | Asynchronous external count input |
| srcExt | input | 1 | 1: count from extPin, 0: count instruction cycles |
| edgeFall | input | 1 | 1: falling pin edge is active, 0: rising |
| psBypass | input | 1 | 1: prescaler not used, 0: prescaler in front of counter |
| psSel | input | 3 | Prescale code k, divide by 2^(k+1) |
| wrEn | input | 1 | Load strobe, taken at the boundary edge |
| wrData | input | 8 | Value to load |
| rdData | output | 8 | Current counter value |

## Verification
A load and a write take effect at the boundary edge where they are applied. An internal increment shows up two boundaries after its event, and a prescaled internal increment three boundaries after the prescaler tap rises. A pin edge needs the synchroniser, one sampling slot and the two-boundary delay, which makes up to about five instruction cycles. The scoreboard tags every expected value with the boundary number it belongs to, and the monitor compares rdData on the falling clock edge right after that boundary. For pin stimulus the expected value is placed eight boundaries after the last edge, well beyond the worst-case latency.

// File: rtl/evtimer_pkg.sv
`timescale 1ns/1ps
package evtimer_pkg;
  // strobes from the control section to the datapath
  typedef struct packed {
    logic tick;     // instruction boundary edge
    logic load;     // processor load at this boundary
    logic psStep;   // advance the prescaler
    logic psClear;  // reset the prescaler
    logic incr;     // advance the counter
  } tmrStrobe_t;
endpackage

// File: rtl/evtimer_ctrl.sv
`timescale 1ns/1ps
module evtimer_ctrl
  import evtimer_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DELAY_TICKS = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] phase,
  input  logic       extPin,
  input  logic       srcExt,
  input  logic       edgeFall,
  input  logic       psBypass,
  input  logic       wrEn,
  input  logic       psBit,
  output tmrStrobe_t strobe
);
  localparam int SL_W = $clog2(DELAY_TICKS + 1) + 1;

  logic [SYNC_STAGES-1:0] syncPipe;
  logic                   prevLvl;
  logic                   sampReg;
  logic                   accum;
  logic [DELAY_TICKS-1:0] dly;
  logic                   extLvl, extEdge, tick, sampleEn, chosenLvl;
  logic                   samplePulse, rawPulse, load, dlyIn;

  assign tick     = (phase == 2'd3);
  assign sampleEn = (phase == 2'd0) || (phase == 2'd2);
  assign load     = tick & wrEn;

  // pin synchroniser, then polarity so the active edge is always a rise
  always_ff @(posedge clk) begin
    if (!rstN) syncPipe <= '0;
    else       syncPipe <= {syncPipe[SYNC_STAGES-2:0], extPin};
  end

  assign extLvl  = syncPipe[SYNC_STAGES-1] ^ edgeFall;
  assign extEdge = extLvl & ~prevLvl;

  always_ff @(posedge clk) begin
    if (!rstN) prevLvl <= 1'b0;
    else       prevLvl <= extLvl;
  end

  // level sampled twice per instruction cycle
  assign chosenLvl   = psBypass ? extLvl : psBit;
  assign samplePulse = sampleEn & chosenLvl & ~sampReg;
  assign rawPulse    = (srcExt || !psBypass) ? samplePulse : tick;

  always_ff @(posedge clk) begin
    if (!rstN)         sampReg <= 1'b0;
    else if (sampleEn) sampReg <= chosenLvl;
  end

  // collect at most one request per instruction cycle
  always_ff @(posedge clk) begin
    if (!rstN)         accum <= 1'b0;
    else if (tick)     accum <= 1'b0;
    else if (rawPulse) accum <= 1'b1;
  end

  assign dlyIn = accum | rawPulse;

  // delay line advanced at boundaries, emptied by a load
  generate
    if (DELAY_TICKS == 1) begin : g_dly1
      always_ff @(posedge clk) begin
        if (!rstN)     dly <= '0;
        else if (tick) dly <= load ? '0 : dlyIn;
      end
    end else begin : g_dlyN
      always_ff @(posedge clk) begin
        if (!rstN)     dly <= '0;
        else if (tick) dly <= load ? '0 : {dly[DELAY_TICKS-2:0], dlyIn};
      end
    end
  endgenerate

  always_comb begin
    strobe.tick    = tick;
    strobe.load    = load;
    strobe.psStep  = ~psBypass & (srcExt ? extEdge : tick);
    strobe.psClear = load & ~psBypass;
    strobe.incr    = tick & dly[DELAY_TICKS-1] & ~load;
  end

  // boundaries since the last load, saturating, for the blanking check
  logic [SL_W-1:0] sinceLoad;
  always_ff @(posedge clk) begin
    if (!rstN) sinceLoad <= '0;
    else if (tick) begin
      if (load) sinceLoad <= '0;
      else if (sinceLoad < SL_W'(DELAY_TICKS)) sinceLoad <= sinceLoad + 1'b1;
    end
  end

  p_blank_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.incr |-> (sinceLoad >= SL_W'(DELAY_TICKS)));

  p_incr_boundary_r2: assert property (@(posedge clk) disable iff (!rstN)
    (phase != 2'd3) |-> !strobe.incr);
endmodule

// File: rtl/evtimer_dp.sv
`timescale 1ns/1ps
module evtimer_dp
  import evtimer_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PS_W  = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  tmrStrobe_t              strobe,
  input  logic [$clog2(PS_W)-1:0] psSel,
  input  logic [CNT_W-1:0]        wrData,
  output logic [CNT_W-1:0]        cnt,
  output logic                    psBit
);
  logic [PS_W-1:0] ps;

  always_ff @(posedge clk) begin
    if (!rstN)            cnt <= '0;
    else if (strobe.load) cnt <= wrData;
    else if (strobe.incr) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               ps <= '0;
    else if (strobe.psClear) ps <= '0;
    else if (strobe.psStep)  ps <= ps + 1'b1;
  end

  // tap k toggles every 2^k steps, one rise per 2^(k+1) steps
  assign psBit = ps[psSel];

  p_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.tick |=> $stable(cnt));

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.incr && !strobe.load && cnt == {CNT_W{1'b1}}) |=> (cnt == '0));

  p_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (cnt == $past(wrData)));

  p_psclear_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.psClear |=> (ps == '0));
endmodule

// File: rtl/event_timer.sv
`timescale 1ns/1ps
module event_timer
  import evtimer_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PS_W        = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DELAY_TICKS = 2,
  localparam int SEL_W      = $clog2(PS_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       phase,
  input  logic             extPin,
  input  logic             srcExt,
  input  logic             edgeFall,
  input  logic             psBypass,
  input  logic [SEL_W-1:0] psSel,
  input  logic             wrEn,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] rdData
);
  tmrStrobe_t strobe;
  logic       psBit;

  evtimer_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .DELAY_TICKS(DELAY_TICKS)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .phase(phase), .extPin(extPin),
    .srcExt(srcExt), .edgeFall(edgeFall), .psBypass(psBypass),
    .wrEn(wrEn), .psBit(psBit), .strobe(strobe)
  );

  evtimer_dp #(
    .CNT_W(CNT_W),
    .PS_W(PS_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .psSel(psSel),
    .wrData(wrData), .cnt(rdData), .psBit(psBit)
  );
endmodule

// File: tb/test_event_timer.sv
`timescale 1ns/1ps
module test_event_timer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] phase = 2'd0;
  logic       extPin = 1'b0;
  logic       srcExt = 1'b0, edgeFall = 1'b0, psBypass = 1'b1;
  logic [2:0] psSel = 3'd0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;

  int checks = 0, fails = 0, outstanding = 0, instrCount = 0;
  bit done = 0;

  typedef struct { int target; logic [7:0] value; string tag; } exp_t;
  exp_t sb[$];

  event_timer i_event_timer (
    .clk(clk), .rstN(rstN), .phase(phase), .extPin(extPin),
    .srcExt(srcExt), .edgeFall(edgeFall), .psBypass(psBypass),
    .psSel(psSel), .wrEn(wrEn), .wrData(wrData), .rdData(rdData)
  );

  always #2 clk = ~clk;

  initial forever begin
    @(posedge clk);
    phase <= phase + 2'd1;
  end

  always @(posedge clk) if (phase == 2'd3) instrCount <= instrCount + 1;

  task automatic check(input logic [7:0] exp, input string tag);
    checks++;
    if (rdData !== exp) begin
      fails++;
      $display("FAIL %s: rdData=%02h expected %02h", tag, rdData, exp);
    end
  endtask

  // monitor: pop expected items and compare at their boundary
  initial forever begin
    exp_t it;
    wait (sb.size() > 0);
    it = sb.pop_front();
    @(negedge clk);
    while (instrCount < it.target) @(negedge clk);
    if (instrCount != it.target) begin
      checks++; fails++;
      $display("FAIL %s: sampled late at %0d, expected %02h", it.tag, instrCount, it.value);
    end else check(it.value, it.tag);
    outstanding--;
  end

  task automatic expectAt(input int tgt, input logic [7:0] v, input string tag);
    exp_t it;
    it.target = tgt; it.value = v; it.tag = tag;
    outstanding++;
    sb.push_back(it);
  endtask

  task automatic drain();
    while (outstanding > 0) @(negedge clk);
  endtask

  task automatic waitCycles(input int n);
    repeat (n * 4) @(negedge clk);
  endtask

  task automatic setCfg(input logic se, input logic ef, input logic byp, input logic [2:0] k);
    @(negedge clk);
    srcExt = se; edgeFall = ef; psBypass = byp; psSel = k;
    waitCycles(8);
  endtask

  task automatic load(input logic [7:0] v, output int w);
    @(negedge clk);
    while (phase != 2'd3) @(negedge clk);
    wrEn = 1'b1; wrData = v;
    @(negedge clk);
    wrEn = 1'b0;
    w = instrCount;
  endtask

  task automatic pulses(input int n, input int hi, input int lo);
    for (int i = 0; i < n; i++) begin
      extPin = 1'b1; repeat (hi) @(negedge clk);
      extPin = 1'b0; repeat (lo) @(negedge clk);
    end
  endtask

  // prescaled internal schedule after a load
  function automatic logic [7:0] psModel(input logic [7:0] v, input int k, input int j);
    int n = 0;
    for (int m = (1 << k); m + 3 <= j; m += (1 << (k + 1))) n++;
    return v + 8'(n);
  endfunction

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run hung, got %0d expected completion", instrCount);
    finishRun();
  end

  initial begin
    int w;
    repeat (6) @(negedge clk);
    check(8'h00, "R1 in reset");
    rstN = 1'b1;
    check(8'h00, "R1 after release");

    // R4, R5, R2: internal source, no prescaler
    waitCycles(5);
    load(8'h40, w);
    expectAt(w,     8'h40, "R4 load value");
    expectAt(w + 1, 8'h40, "R5 blank 1");
    expectAt(w + 2, 8'h40, "R5 blank 2");
    expectAt(w + 3, 8'h41, "R5 first increment");
    expectAt(w + 4, 8'h42, "R2 per boundary");
    expectAt(w + 10, 8'h48, "R2 steady count");
    drain();

    // R3 wrap
    load(8'hFE, w);
    expectAt(w + 3, 8'hFF, "R3 before wrap");
    expectAt(w + 4, 8'h00, "R3 wrap to 00");
    expectAt(w + 5, 8'h01, "R3 after wrap");
    drain();

    // R8 pin ignored with internal source
    load(8'h20, w);
    expectAt(w + 2, 8'h20, "R8 pin ignored a");
    expectAt(w + 6, 8'h24, "R8 pin ignored b");
    expectAt(w + 12, 8'h2A, "R8 pin ignored c");
    pulses(14, 2, 2);
    drain();

    // R6 internal prescaler divide by 4
    setCfg(1'b0, 1'b0, 1'b0, 3'd1);
    load(8'h00, w);
    for (int j = 1; j <= 14; j++) expectAt(w + j, psModel(8'h00, 1, j), "R6 divide by 4");
    drain();

    // R7 load mid-run clears the prescaler (divide by 8)
    setCfg(1'b0, 1'b0, 1'b0, 3'd2);
    load(8'h00, w);
    waitCycles(5);
    load(8'h80, w);
    expectAt(w + 6, psModel(8'h80, 2, 6), "R7 before first step");
    expectAt(w + 7, psModel(8'h80, 2, 7), "R7 first step");
    expectAt(w + 14, psModel(8'h80, 2, 14), "R7 holding");
    expectAt(w + 15, psModel(8'h80, 2, 15), "R7 second step");
    drain();

    // R9 external, rising edge
    setCfg(1'b1, 1'b0, 1'b1, 3'd0);
    load(8'h10, w);
    waitCycles(3);
    extPin = 1'b1;
    waitCycles(1);
    expectAt(instrCount + 8, 8'h11, "R9 rising counted");
    drain();
    extPin = 1'b0;
    waitCycles(1);
    expectAt(instrCount + 8, 8'h11, "R9 falling ignored");
    drain();

    // R9 external, falling edge
    setCfg(1'b1, 1'b1, 1'b1, 3'd0);
    load(8'h30, w);
    waitCycles(3);
    extPin = 1'b1;
    waitCycles(1);
    expectAt(instrCount + 8, 8'h30, "R9 rising ignored");
    drain();
    extPin = 1'b0;
    waitCycles(1);
    expectAt(instrCount + 8, 8'h31, "R9 falling counted");
    drain();
    pulses(5, 8, 8);
    expectAt(instrCount + 8, 8'h36, "R9 pulse train");
    drain();

    // R10 external with prescaler
    setCfg(1'b1, 1'b0, 1'b0, 3'd0);
    load(8'h00, w);
    waitCycles(3);
    pulses(6, 2, 2);
    expectAt(instrCount + 8, 8'h03, "R10 divide by 2");
    drain();
    setCfg(1'b1, 1'b0, 1'b0, 3'd1);
    load(8'h00, w);
    waitCycles(3);
    pulses(10, 2, 2);
    expectAt(instrCount + 8, 8'h03, "R10 divide by 4");
    drain();

    done = 1;
    finishRun();
  end
endmodule